// File: doc/BRIEF.md
# Image Sensor Row-Overhead Sequencer

This block generates the control pulses that a CMOS image sensor needs in the gap between two line readouts, the row overhead time. A one-cycle line-start strobe starts a sequence. The sequence drives a column-precharge pulse and a row-deselect pulse, which both begin on the same clock. Depending on the selected mode, the sequence can also drive an active-low column sample-hold pulse, a pair of short bus-precharge pulses and a voltage-averaging pulse. When the overhead period is over, a one-cycle ready pulse tells the readout logic that pixel sampling may begin.

Two modes are available. In standard mode, the sample-hold line stays low at all times. The overhead period is the precharge width plus a settle time. In sample-and-hold mode, the sample-hold line is low for a programmed width, starting with the precharge pulse. That width sets the overhead period. An enabled averaging pulse follows the sample-hold pulse, and the ready pulse comes after it.

All durations are counts of the system clock. They are loaded together with the mode and the option enables through a load strobe, which is accepted only while the block is idle. A duration that breaks its rule is corrected as it is loaded. At the default 100 MHz clock, a 2-cycle precharge and an 18-cycle settle give a 200 ns standard overhead.

Top module: `rot_seq`

## Requirements
- R1: An accepted line-start (block idle) makes `col_pre` and `row_desel` rise together on the next clock. Both stay high for exactly T_PRE cycles.
- R2: In standard mode (`cfg_mode_sh`=0 when loaded), `pix_ready` is high in the cycle that comes T_PRE+T_SETTLE cycles after the first cycle of the precharge pulse.
- R3: In standard mode, `sh_col_n` is held at 0 continuously, both while idle and during a sequence.
- R4: In sample-and-hold mode (`cfg_mode_sh`=1), `sh_col_n` is 1 while idle. It is 0 for T_SH cycles starting with the precharge pulse. Without averaging, `pix_ready` is high in the first cycle in which `sh_col_n` has returned to 1.
- R5: In sample-and-hold mode with `cfg_avg_en`=1, `avg_pulse` is high for T_AVG cycles, starting in the cycle in which `sh_col_n` returns to 1. `pix_ready` follows in the cycle after `avg_pulse` falls. In standard mode, `cfg_avg_en` has no effect.
- R6: With `cfg_bus_en`=1, `bus_pre1` and `bus_pre2` are both high for T_BUS cycles starting with the precharge pulse, in either mode. With `cfg_bus_en`=0, both stay low.
- R7: A load turns a zero T_PRE, T_SETTLE, T_BUS or T_AVG into 1. It raises T_SH to T_PRE if T_SH is smaller. It limits T_BUS to T_PRE.
- R8: A `cfg_load` that arrives during a sequence is ignored. The running sequence and the later sequences keep the previous settings.
- R9: A line-start that arrives during a sequence, including the ready cycle, starts nothing. It sets `overrun`, and `overrun` stays set until reset.
- R10: `pix_ready` lasts one cycle. After it, and after reset, `col_pre`, `row_desel`, `bus_pre1`, `bus_pre2` and `avg_pulse` are low and `sh_col_n` is at its idle level. Reset loads standard mode with both options off, and `overrun` is 0 after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| line_start | input | 1 | One-cycle strobe that selects a new line |
| cfg_load | input | 1 | Loads the settings below (accepted only while idle) |
| cfg_mode_sh | input | 1 | 0 = standard mode, 1 = sample-and-hold mode |
| cfg_bus_en | input | 1 | Enables the bus-precharge pulses |
| cfg_avg_en | input | 1 | Enables the averaging pulse (sample-and-hold mode only) |
| cfg_t_pre | input | 8 | Width of the precharge and deselect pulses, in cycles |
| cfg_t_settle | input | 8 | Settle cycles after precharge in standard mode |
| cfg_t_sh | input | 8 | Width of the sample-hold pulse, in cycles |
| cfg_t_bus | input | 8 | Width of the bus-precharge pulse, in cycles |
| cfg_t_avg | input | 8 | Width of the averaging pulse, in cycles |
| col_pre | output | 1 | Column precharge, active high |
| row_desel | output | 1 | Row deselect, active high |
| sh_col_n | output | 1 | Column sample-hold, active low |
| bus_pre1 | output | 1 | Output bus 1 precharge, active high |
| bus_pre2 | output | 1 | Output bus 2 precharge, active high |
| avg_pulse | output | 1 | Voltage-averaging pulse, active high |
| pix_ready | output | 1 | One-cycle strobe: pixel sampling may start |
| overrun | output | 1 | Sticky: a line-start arrived during a sequence |

## Verification
Two events can meet on one clock edge. A new line-start can arrive in the very cycle that `pix_ready` ends a sequence, and a `cfg_load` can arrive in the middle of a running sequence. The bench drives a line-start in the ready cycle itself and then checks three things: the following cycle is idle with no precharge, `overrun` is set, and the next sequence still matches the prediction. A load is issued partway through a sequence, and the bench checks that the current and next waveforms still follow the settings held before that load.

// File: rtl/rot_pkg.sv
package rot_pkg;

    localparam int ROT_CW = 8;

    typedef enum logic {
        MODE_STD = 1'b0,
        MODE_SH  = 1'b1
    } rot_mode_e;

    typedef struct packed {
        rot_mode_e         mode;
        logic              en_bus;
        logic              en_avg;
        logic [ROT_CW-1:0] t_pre;
        logic [ROT_CW-1:0] t_settle;
        logic [ROT_CW-1:0] t_sh;
        logic [ROT_CW-1:0] t_bus;
        logic [ROT_CW-1:0] t_avg;
    } rot_cfg_t;

    function automatic logic [ROT_CW-1:0] floor_one(input logic [ROT_CW-1:0] v);
        return (v == '0) ? ROT_CW'(1) : v;
    endfunction

endpackage

// File: rtl/rot_cfg.sv
module rot_cfg
    import rot_pkg::*;
#(
    parameter int DEF_PRE    = 2,
    parameter int DEF_SETTLE = 18,
    parameter int DEF_SH     = 15,
    parameter int DEF_BUS    = 1,
    parameter int DEF_AVG    = 2
) (
    input  logic     clk,
    input  logic     rst_n,
    input  logic     load,
    input  logic     busy,
    input  rot_cfg_t cfg_in,
    output rot_cfg_t cfg_out
);

    rot_cfg_t          cfg_d, cfg_q;
    logic [ROT_CW-1:0] pre_fix;
    logic [ROT_CW-1:0] bus_fix;

    always_comb begin
        cfg_d   = cfg_q;
        pre_fix = floor_one(cfg_in.t_pre);
        bus_fix = floor_one(cfg_in.t_bus);
        if (bus_fix > pre_fix) bus_fix = pre_fix;
        if (load && !busy) begin
            cfg_d.mode     = cfg_in.mode;
            cfg_d.en_bus   = cfg_in.en_bus;
            cfg_d.en_avg   = cfg_in.en_avg;
            cfg_d.t_pre    = pre_fix;
            cfg_d.t_settle = floor_one(cfg_in.t_settle);
            cfg_d.t_sh     = (cfg_in.t_sh < pre_fix) ? pre_fix : cfg_in.t_sh;
            cfg_d.t_bus    = bus_fix;
            cfg_d.t_avg    = floor_one(cfg_in.t_avg);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q.mode     <= MODE_STD;
            cfg_q.en_bus   <= 1'b0;
            cfg_q.en_avg   <= 1'b0;
            cfg_q.t_pre    <= ROT_CW'(DEF_PRE);
            cfg_q.t_settle <= ROT_CW'(DEF_SETTLE);
            cfg_q.t_sh     <= ROT_CW'(DEF_SH);
            cfg_q.t_bus    <= ROT_CW'(DEF_BUS);
            cfg_q.t_avg    <= ROT_CW'(DEF_AVG);
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign cfg_out = cfg_q;

endmodule

// File: rtl/rot_timer.sv
module rot_timer #(
    parameter int CW = 9
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          line_start,
    input  logic [CW-1:0] end_cnt,
    output logic          busy,
    output logic [CW-1:0] cnt,
    output logic          ready,
    output logic          overrun
);

    typedef struct packed {
        logic          busy;
        logic          ovr;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t s_d, s_q;
    logic at_end;

    always_comb begin
        s_d    = s_q;
        at_end = s_q.busy && (s_q.cnt == end_cnt);
        if (s_q.busy) begin
            if (line_start) s_d.ovr = 1'b1;
            if (at_end) begin
                s_d.busy = 1'b0;
                s_d.cnt  = '0;
            end else begin
                s_d.cnt = s_q.cnt + 1'b1;
            end
        end else if (line_start) begin
            s_d.busy = 1'b1;
            s_d.cnt  = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy    = s_q.busy;
    assign cnt     = s_q.cnt;
    assign ready   = at_end;
    assign overrun = s_q.ovr;

endmodule

// File: rtl/rot_decode.sv
module rot_decode
    import rot_pkg::*;
#(
    parameter int CW = ROT_CW + 1
) (
    input  rot_cfg_t      cfg,
    input  logic          busy,
    input  logic [CW-1:0] cnt,
    output logic [CW-1:0] end_cnt,
    output logic          pre_on,
    output logic          bus_on,
    output logic          sh_n,
    output logic          avg_on
);

    logic [CW-1:0] pre_w, set_w, sh_w, bus_w, avg_w;
    logic          sh_mode, use_avg;

    always_comb begin
        pre_w   = CW'(cfg.t_pre);
        set_w   = CW'(cfg.t_settle);
        sh_w    = CW'(cfg.t_sh);
        bus_w   = CW'(cfg.t_bus);
        avg_w   = CW'(cfg.t_avg);
        sh_mode = (cfg.mode == MODE_SH);
        use_avg = sh_mode && cfg.en_avg;
        if (sh_mode) end_cnt = sh_w + (use_avg ? avg_w : '0);
        else         end_cnt = pre_w + set_w;
        pre_on = busy && (cnt < pre_w);
        bus_on = busy && cfg.en_bus && (cnt < bus_w);
        sh_n   = sh_mode ? !(busy && (cnt < sh_w)) : 1'b0;
        avg_on = busy && use_avg && (cnt >= sh_w) && (cnt < sh_w + avg_w);
    end

endmodule

// File: rtl/rot_seq.sv
module rot_seq
    import rot_pkg::*;
#(
    parameter int DEF_PRE    = 2,
    parameter int DEF_SETTLE = 18,
    parameter int DEF_SH     = 15,
    parameter int DEF_BUS    = 1,
    parameter int DEF_AVG    = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_start,
    input  logic              cfg_load,
    input  logic              cfg_mode_sh,
    input  logic              cfg_bus_en,
    input  logic              cfg_avg_en,
    input  logic [ROT_CW-1:0] cfg_t_pre,
    input  logic [ROT_CW-1:0] cfg_t_settle,
    input  logic [ROT_CW-1:0] cfg_t_sh,
    input  logic [ROT_CW-1:0] cfg_t_bus,
    input  logic [ROT_CW-1:0] cfg_t_avg,
    output logic              col_pre,
    output logic              row_desel,
    output logic              sh_col_n,
    output logic              bus_pre1,
    output logic              bus_pre2,
    output logic              avg_pulse,
    output logic              pix_ready,
    output logic              overrun
);

    localparam int CW = ROT_CW + 1;

    rot_cfg_t      cfg_in, cfg_w;
    logic          busy_w;
    logic [CW-1:0] cnt_w, end_w;
    logic          pre_on, bus_on, sh_n, avg_on;

    always_comb begin
        cfg_in.mode     = rot_mode_e'(cfg_mode_sh);
        cfg_in.en_bus   = cfg_bus_en;
        cfg_in.en_avg   = cfg_avg_en;
        cfg_in.t_pre    = cfg_t_pre;
        cfg_in.t_settle = cfg_t_settle;
        cfg_in.t_sh     = cfg_t_sh;
        cfg_in.t_bus    = cfg_t_bus;
        cfg_in.t_avg    = cfg_t_avg;
    end

    rot_cfg #(
        .DEF_PRE(DEF_PRE), .DEF_SETTLE(DEF_SETTLE), .DEF_SH(DEF_SH),
        .DEF_BUS(DEF_BUS), .DEF_AVG(DEF_AVG)
    ) cfg_i (
        .clk(clk), .rst_n(rst_n), .load(cfg_load), .busy(busy_w),
        .cfg_in(cfg_in), .cfg_out(cfg_w)
    );

    rot_timer #(.CW(CW)) tmr_i (
        .clk(clk), .rst_n(rst_n), .line_start(line_start), .end_cnt(end_w),
        .busy(busy_w), .cnt(cnt_w), .ready(pix_ready), .overrun(overrun)
    );

    rot_decode #(.CW(CW)) dec_i (
        .cfg(cfg_w), .busy(busy_w), .cnt(cnt_w), .end_cnt(end_w),
        .pre_on(pre_on), .bus_on(bus_on), .sh_n(sh_n), .avg_on(avg_on)
    );

    assign col_pre   = pre_on;
    assign row_desel = pre_on;
    assign sh_col_n  = sh_n;
    assign bus_pre1  = bus_on;
    assign bus_pre2  = bus_on;
    assign avg_pulse = avg_on;

endmodule

// File: rtl/rot_seq_chk.sv
module rot_seq_chk
    import rot_pkg::*;
(
    input logic     clk,
    input logic     rst_n,
    input logic     line_start,
    input logic     busy,
    input rot_cfg_t cfg,
    input logic     col_pre,
    input logic     row_desel,
    input logic     sh_col_n,
    input logic     bus_pre1,
    input logic     bus_pre2,
    input logic     avg_pulse,
    input logic     pix_ready,
    input logic     overrun
);

    AST_PULSE_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> (col_pre && row_desel)); // R1
    AST_STD_SH_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.mode == MODE_STD) |-> !sh_col_n); // R3
    AST_AVG_AFTER_SH: assert property (@(posedge clk) disable iff (!rst_n)
        avg_pulse |-> (cfg.mode == MODE_SH && sh_col_n && !col_pre)); // R5
    AST_BUS_IN_PRE: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_pre1 || bus_pre2) |-> col_pre); // R6
    AST_PRE_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg.t_pre != '0) && (cfg.t_sh >= cfg.t_pre)); // R7
    AST_CFG_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && $past(busy)) |-> $stable(cfg)); // R8
    AST_OVR_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && line_start) |=> overrun); // R9
    AST_OVR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun); // R9
    AST_READY_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |=> !pix_ready && !col_pre && !avg_pulse); // R10

endmodule

bind rot_seq rot_seq_chk chk_i (
    .clk(clk), .rst_n(rst_n), .line_start(line_start), .busy(busy_w),
    .cfg(cfg_w), .col_pre(col_pre), .row_desel(row_desel),
    .sh_col_n(sh_col_n), .bus_pre1(bus_pre1), .bus_pre2(bus_pre2),
    .avg_pulse(avg_pulse), .pix_ready(pix_ready), .overrun(overrun)
);

// File: tb/rot_seq_tb_top.sv
module rot_seq_tb_top;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic line_start = 1'b0, cfg_load = 1'b0;
    logic cfg_mode_sh = 1'b0, cfg_bus_en = 1'b0, cfg_avg_en = 1'b0;
    logic [7:0] cfg_t_pre = '0, cfg_t_settle = '0, cfg_t_sh = '0, cfg_t_bus = '0, cfg_t_avg = '0;
    logic col_pre, row_desel, sh_col_n, bus_pre1, bus_pre2, avg_pulse, pix_ready, overrun;

    int total = 0, bad = 0;
    bit done = 0;
    // bench model of the loaded settings (reset defaults)
    bit m_sh = 0, m_bus = 0, m_avg = 0, m_ovr = 0;
    int m_pre = 2, m_set = 18, m_shw = 15, m_busw = 1, m_avgw = 2;

    always #5 clk = ~clk;

    rot_seq dut_i (.*);

    task automatic chk(input int act, input int exp, input string tag, input string what);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int fl1(input int v);
        return (v == 0) ? 1 : v;
    endfunction

    function automatic int end_cycle();
        if (m_sh) return m_shw + (m_avg ? m_avgw : 0);
        return m_pre + m_set;
    endfunction

    task automatic check_idle(input string tag);
        chk(col_pre, 0, tag, "idle col_pre");
        chk(row_desel, 0, tag, "idle row_desel");
        chk(bus_pre1 | bus_pre2, 0, tag, "idle bus_pre");
        chk(avg_pulse, 0, tag, "idle avg_pulse");
        chk(pix_ready, 0, tag, "idle pix_ready");
        chk(sh_col_n, m_sh ? 1 : 0, m_sh ? "R4" : "R3", "idle sh_col_n");
        chk(overrun, m_ovr, "R9", "overrun");
    endtask

    task automatic do_load(input bit sh, input bit be, input bit ae,
                           input int p, input int s, input int h, input int b, input int a);
        int pf;
        @(negedge clk);
        cfg_mode_sh = sh; cfg_bus_en = be; cfg_avg_en = ae;
        cfg_t_pre = 8'(p); cfg_t_settle = 8'(s); cfg_t_sh = 8'(h);
        cfg_t_bus = 8'(b); cfg_t_avg = 8'(a); cfg_load = 1'b1;
        @(negedge clk);
        cfg_load = 1'b0;
        pf = fl1(p);
        m_sh = sh; m_bus = be; m_avg = ae;
        m_pre = pf; m_set = fl1(s); m_shw = (h < pf) ? pf : h;
        m_busw = (fl1(b) > pf) ? pf : fl1(b); m_avgw = fl1(a);
        check_idle("R7");
    endtask

    // inj_ls / inj_cfg: cycle index at which a line-start / load is injected, -1 for none
    task automatic run_seq(input int inj_ls, input int inj_cfg, input string ctx);
        int e;
        e = end_cycle();
        @(negedge clk);
        line_start = 1'b1;
        @(negedge clk);
        line_start = 1'b0;
        for (int k = 0; k <= e; k++) begin
            chk(col_pre, k < m_pre, "R1", {ctx, " col_pre"});
            chk(row_desel, k < m_pre, "R1", {ctx, " row_desel"});
            chk(sh_col_n, m_sh ? (k >= m_shw) : 0, m_sh ? "R4" : "R3", {ctx, " sh_col_n"});
            chk(bus_pre1, m_bus && k < m_busw, "R6", {ctx, " bus_pre1"});
            chk(bus_pre2, m_bus && k < m_busw, "R6", {ctx, " bus_pre2"});
            chk(avg_pulse, m_sh && m_avg && k >= m_shw && k < m_shw + m_avgw, "R5", {ctx, " avg_pulse"});
            chk(pix_ready, k == e, m_sh ? (m_avg ? "R5" : "R4") : "R2", {ctx, " pix_ready"});
            line_start = (k == inj_ls);
            cfg_load = (k == inj_cfg);
            if (k == inj_cfg) begin
                cfg_mode_sh = ~m_sh; cfg_bus_en = ~m_bus; cfg_avg_en = 1'b1;
                cfg_t_pre = 8'd7; cfg_t_settle = 8'd3; cfg_t_sh = 8'd9;
                cfg_t_bus = 8'd4; cfg_t_avg = 8'd5;
            end
            if (k == inj_ls) m_ovr = 1;
            @(negedge clk);
        end
        line_start = 1'b0;
        cfg_load = 1'b0;
        check_idle("R10");
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle("R10");                                    // reset state
        run_seq(-1, -1, "R2 default");                        // 20-cycle standard overhead
        do_load(0, 1, 1, 3, 5, 0, 2, 4);
        run_seq(-1, -1, "R5 avg ignored in std");
        do_load(1, 0, 0, 2, 1, 10, 1, 1);
        run_seq(-1, -1, "R4 sh");
        do_load(1, 1, 1, 2, 1, 6, 1, 3);
        run_seq(-1, -1, "R5 sh+avg");
        do_load(1, 1, 0, 0, 0, 0, 0, 0);                      // all zeros
        run_seq(-1, -1, "R7 zeros");
        do_load(1, 1, 1, 5, 2, 3, 9, 0);                      // sh raised, bus limited
        run_seq(-1, -1, "R7 clamp");
        run_seq(-1, 3, "R8 load mid-seq");
        run_seq(-1, -1, "R8 after");
        do_load(0, 1, 0, 2, 4, 1, 1, 1);
        run_seq(end_cycle(), -1, "R9 start on ready");
        run_seq(2, -1, "R9 start mid");
        for (int i = 0; i < 40; i++) begin
            do_load($urandom_range(0, 1), $urandom_range(0, 1), $urandom_range(0, 1),
                    $urandom_range(0, 6), $urandom_range(0, 9), $urandom_range(0, 12),
                    $urandom_range(0, 7), $urandom_range(0, 5));
            run_seq(($urandom_range(0, 7) == 0) ? 1 : -1,
                    ($urandom_range(0, 7) == 0) ? 0 : -1, "random");
        end
        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(10 * 100000);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule